// File: doc/BRIEF.md
# Hex-Text Command Frame Decoder

This block sits behind a serial host link that delivers one character per cycle on a valid/data pair. It searches the stream for the lower-case letter `z` (0x7A). After it come three kinds of field: a task identifier, a byte count and as many parameter bytes as the count gives. Each field is one byte written as two ASCII hexadecimal characters. The decoder turns each character pair into a binary byte and presents it on the output that matches its field, with a one-cycle valid strobe.

The decoder reports a finished frame with a one-cycle done pulse. When a frame breaks, it raises a one-cycle error pulse. A downstream task dispatcher consumes the task identifier, the count and the parameter stream. The decoder does not run any task itself. Characters outside a frame are dropped without effect. A fresh `z` always wins, so a host can resynchronise by sending `z` again.

Top module: `hexcmd_parser`

## Requirements
- R1: While `rst_n` is low at a clock edge, all strobes (`task_valid`, `count_valid`, `param_valid`, `frame_done`, `frame_err`) are 0 after that edge, and `task_id`, `byte_count` and `param_data` are 0.
- R2: When no frame is open, any accepted character other than 0x7A (`z`) causes no strobe and no error.
- R3: After `z`, the next two hex characters form the task identifier, high nibble first. `task_valid` pulses for one cycle, with `task_id` holding that byte, in the cycle after the second character is accepted.
- R4: The characters `0`-`9`, `A`-`F` and `a`-`f` are all accepted as hex digits, with values 0-15. Upper and lower case give the same value.
- R5: The pair after the task identifier is the byte count. It appears on `byte_count` with a one-cycle `count_valid` pulse.
- R6: Each later pair appears on `param_data` with a one-cycle `param_valid` pulse. Exactly `byte_count` such bytes belong to the frame.
- R7: `frame_done` pulses in the same cycle as the last `param_valid`. When the count is 0, it pulses with `count_valid` instead. After that the decoder searches for `z` again.
- R8: A character inside an open frame that is neither hex nor `z` gives a one-cycle `frame_err` pulse and closes the frame. Hex characters after that are ignored until the next `z`.
- R9: A `z` inside an open frame drops the partial frame without an error, including any half-received pair, and opens a new frame.
- R10: Cycles with `in_valid` low do not advance decoding, and no strobe follows them.
- R11: Every strobe is registered, appearing one cycle after the character that caused it. At most one of `task_valid`, `count_valid` and `param_valid` is high in any cycle. `task_id` holds its value except when `task_valid` pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A character is present on `in_data` |
| in_data | input | 8 | ASCII character from the host link |
| task_valid | output | 1 | One-cycle strobe: `task_id` is new |
| task_id | output | 8 | Decoded task identifier |
| count_valid | output | 1 | One-cycle strobe: `byte_count` is new |
| byte_count | output | 8 | Decoded parameter byte count |
| param_valid | output | 1 | One-cycle strobe: `param_data` is new |
| param_data | output | 8 | Decoded parameter byte |
| frame_done | output | 1 | One-cycle pulse: frame complete |
| frame_err | output | 1 | One-cycle pulse: illegal character in a frame |

## Verification
The riskiest internal state is the pair half and the field pointer. A pair half that has slipped puts wrong nibble-swapped bytes on the port at the very next strobe. A stale field pointer sends a byte to the wrong strobe in that same cycle. A wrong remaining-byte counter shows up when the last parameter of a frame arrives: `frame_done` comes too early or too late, or a stray `param_valid` follows. The comparison runs every cycle against a behavioural model, so each of these faults is caught within one cycle of the character that exposes it.

// File: rtl/hexcmd_pkg.sv
// Shared definitions for the hex-text command frame decoder.
// Assumes 8-bit ASCII characters on the input.
package hexcmd_pkg;
    localparam int unsigned CHAR_W = 8;
    localparam logic [CHAR_W-1:0] START_CHAR = 8'h7A;

    typedef enum logic [1:0] {
        FLD_IDLE  = 2'd0,
        FLD_TASK  = 2'd1,
        FLD_COUNT = 2'd2,
        FLD_PARAM = 2'd3
    } field_e;
endpackage

// File: rtl/hexcmd_nibble.sv
// Converts one ASCII character to a 4-bit hex value.
// Purely combinational. Non-hex characters give is_hex = 0 and nib = 0.
module hexcmd_nibble #(
    parameter int unsigned CHAR_W = 8
) (
    input  logic [CHAR_W-1:0] ch,
    output logic              is_hex,
    output logic [3:0]        nib
);
    localparam logic [CHAR_W-1:0] C_0  = CHAR_W'(8'h30);
    localparam logic [CHAR_W-1:0] C_9  = CHAR_W'(8'h39);
    localparam logic [CHAR_W-1:0] C_UA = CHAR_W'(8'h41);
    localparam logic [CHAR_W-1:0] C_UF = CHAR_W'(8'h46);
    localparam logic [CHAR_W-1:0] C_LA = CHAR_W'(8'h61);
    localparam logic [CHAR_W-1:0] C_LF = CHAR_W'(8'h66);

    logic [CHAR_W-1:0] diff;

    // Classify the character and compute its digit value.
    always_comb begin
        is_hex = 1'b0;
        diff   = '0;
        if (ch >= C_0 && ch <= C_9) begin
            is_hex = 1'b1;
            diff   = ch - C_0;
        end else if (ch >= C_UA && ch <= C_UF) begin
            is_hex = 1'b1;
            diff   = ch - C_UA + CHAR_W'(10);
        end else if (ch >= C_LA && ch <= C_LF) begin
            is_hex = 1'b1;
            diff   = ch - C_LA + CHAR_W'(10);
        end
        nib = diff[3:0];
    end
endmodule

// File: rtl/hexcmd_pair.sv
// Joins two nibble characters into a byte, high nibble first.
// Assumes that clear has priority over load. byte_ready is combinational
// and is valid in the cycle the second nibble is loaded.
module hexcmd_pair (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       load,
    input  logic [3:0] nib,
    output logic       byte_ready,
    output logic [7:0] byte_val
);
    logic       have_hi;
    logic [3:0] hi_q;

    // Track which half of the pair comes next and keep the high nibble.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            have_hi <= 1'b0;
            hi_q    <= '0;
        end else if (load) begin
            have_hi <= !have_hi;
            if (!have_hi) hi_q <= nib;
        end
    end

    // Present the finished byte when the low nibble arrives.
    always_comb begin
        byte_ready = load && !clear && have_hi;
        byte_val   = {hi_q, nib};
    end
endmodule

// File: rtl/hexcmd_seq.sv
// Field sequencer: sends each decoded byte to task, count or parameter,
// and counts the parameter bytes down. All outputs are registered.
// Assumes that start, bad and byte_ready are already qualified by the top.
module hexcmd_seq
    import hexcmd_pkg::*;
#(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              bad,
    input  logic              byte_ready,
    input  logic [BYTE_W-1:0] byte_val,
    output logic              in_frame,
    output logic              task_valid,
    output logic [BYTE_W-1:0] task_id,
    output logic              count_valid,
    output logic [BYTE_W-1:0] byte_count,
    output logic              param_valid,
    output logic [BYTE_W-1:0] param_data,
    output logic              frame_done,
    output logic              frame_err
);
    localparam logic [BYTE_W-1:0] ONE = BYTE_W'(1);

    field_e            fld;
    logic [BYTE_W-1:0] remain;

    // Field state, remaining count and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fld         <= FLD_IDLE;
            remain      <= '0;
            task_valid  <= 1'b0;
            count_valid <= 1'b0;
            param_valid <= 1'b0;
            frame_done  <= 1'b0;
            frame_err   <= 1'b0;
            task_id     <= '0;
            byte_count  <= '0;
            param_data  <= '0;
        end else begin
            task_valid  <= 1'b0;
            count_valid <= 1'b0;
            param_valid <= 1'b0;
            frame_done  <= 1'b0;
            frame_err   <= 1'b0;
            if (start) begin
                fld <= FLD_TASK;
            end else if (bad) begin
                frame_err <= 1'b1;
                fld       <= FLD_IDLE;
            end else if (byte_ready) begin
                unique case (fld)
                    FLD_TASK: begin
                        task_valid <= 1'b1;
                        task_id    <= byte_val;
                        fld        <= FLD_COUNT;
                    end
                    FLD_COUNT: begin
                        count_valid <= 1'b1;
                        byte_count  <= byte_val;
                        remain      <= byte_val;
                        if (byte_val == '0) begin
                            frame_done <= 1'b1;
                            fld        <= FLD_IDLE;
                        end else begin
                            fld <= FLD_PARAM;
                        end
                    end
                    FLD_PARAM: begin
                        param_valid <= 1'b1;
                        param_data  <= byte_val;
                        remain      <= remain - ONE;
                        if (remain == ONE) begin
                            frame_done <= 1'b1;
                            fld        <= FLD_IDLE;
                        end
                    end
                    default: fld <= FLD_IDLE;
                endcase
            end
        end
    end

    // A frame is open whenever the field pointer is not idle.
    always_comb in_frame = (fld != FLD_IDLE);
endmodule

// File: rtl/hexcmd_parser.sv
// Top of the hex-text command frame decoder. Classifies each incoming
// character (start, hex digit or illegal), pairs the digits into bytes and
// passes them to the field sequencer. Assumes one character per cycle at most.
module hexcmd_parser
    import hexcmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    output logic        task_valid,
    output logic [7:0]  task_id,
    output logic        count_valid,
    output logic [7:0]  byte_count,
    output logic        param_valid,
    output logic [7:0]  param_data,
    output logic        frame_done,
    output logic        frame_err
);
    logic       is_hex;
    logic [3:0] nib;
    logic       in_frame;
    logic       is_start;
    logic       hex_ok;
    logic       bad;
    logic       byte_ready;
    logic [7:0] byte_val;

    hexcmd_nibble #(.CHAR_W(CHAR_W)) u_nib (
        .ch     (in_data),
        .is_hex (is_hex),
        .nib    (nib)
    );

    // Qualify the character against the current frame state.
    always_comb begin
        is_start = in_valid && (in_data == START_CHAR);
        hex_ok   = in_valid && in_frame && is_hex;
        bad      = in_valid && in_frame && !is_hex && !is_start;
    end

    hexcmd_pair u_pair (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (is_start || bad),
        .load       (hex_ok),
        .nib        (nib),
        .byte_ready (byte_ready),
        .byte_val   (byte_val)
    );

    hexcmd_seq #(.BYTE_W(8)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (is_start),
        .bad         (bad),
        .byte_ready  (byte_ready),
        .byte_val    (byte_val),
        .in_frame    (in_frame),
        .task_valid  (task_valid),
        .task_id     (task_id),
        .count_valid (count_valid),
        .byte_count  (byte_count),
        .param_valid (param_valid),
        .param_data  (param_data),
        .frame_done  (frame_done),
        .frame_err   (frame_err)
    );
endmodule

// File: rtl/hexcmd_parser_chk.sv
// Protocol checker for the decoder outputs. It is attached to the top by
// the bind statement at the end of this file.
module hexcmd_parser_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       task_valid,
    input logic [7:0] task_id,
    input logic       count_valid,
    input logic [7:0] byte_count,
    input logic       param_valid,
    input logic       frame_done,
    input logic       frame_err
);
    logic seen;

    // Set once a cycle has passed out of reset, so $past is meaningful.
    always_ff @(posedge clk) seen <= rst_n;

    assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({task_valid, count_valid, param_valid}));

    assert_done_with_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (param_valid || count_valid));

    assert_zero_count_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (count_valid && byte_count == 8'h00) |-> frame_done);

    assert_err_alone_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> !(task_valid || count_valid || param_valid || frame_done));

    assert_idle_input_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !$past(in_valid)) |-> !(task_valid || count_valid || param_valid || frame_err));

    assert_task_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !task_valid) |-> $stable(task_id));
endmodule

bind hexcmd_parser hexcmd_parser_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .task_valid  (task_valid),
    .task_id     (task_id),
    .count_valid (count_valid),
    .byte_count  (byte_count),
    .param_valid (param_valid),
    .frame_done  (frame_done),
    .frame_err   (frame_err)
);

// File: tb/sim_hexcmd_parser.sv
module sim_hexcmd_parser;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       task_valid, count_valid, param_valid, frame_done, frame_err;
    logic [7:0] task_id, byte_count, param_data;

    int tests = 0;
    int fails = 0;
    logic [8:0] stim[$];

    // behavioural reference state
    int m_fld = 0;      // 0 search, 1 task, 2 count, 3 params
    int m_half = 0;
    int m_hi = 0;
    int m_left = 0;
    logic       e_tv = 0, e_cv = 0, e_pv = 0, e_done = 0, e_err = 0;
    logic [7:0] e_tid = 0, e_cnt = 0, e_par = 0;

    int n_tv = 0, n_cv = 0, n_pv = 0, n_done = 0, n_err = 0;

    always #5 clk = ~clk;

    hexcmd_parser u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .task_valid(task_valid), .task_id(task_id),
        .count_valid(count_valid), .byte_count(byte_count),
        .param_valid(param_valid), .param_data(param_data),
        .frame_done(frame_done), .frame_err(frame_err)
    );

    function automatic int hexval(input logic [7:0] c);
        if (c >= "0" && c <= "9") return int'(c) - 48;
        if (c >= "A" && c <= "F") return int'(c) - 55;
        if (c >= "a" && c <= "f") return int'(c) - 87;
        return -1;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
        end
    endtask

    task automatic put(input string s);
        for (int i = 0; i < s.len(); i++) stim.push_back({1'b1, s[i]});
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) stim.push_back(9'h000);
    endtask

    task automatic drain();
        wait (stim.size() == 0);
        repeat (3) @(posedge clk);
        #1;
    endtask

    // Per-cycle compare, stimulus issue and reference model update.
    always @(negedge clk) begin
        int hv;
        int b;
        logic [8:0] e;
        if (rst_n) begin
            check("R3 R11 task_valid", {7'd0, task_valid}, {7'd0, e_tv});
            check("R3 task_id", task_id, e_tid);
            check("R5 count_valid", {7'd0, count_valid}, {7'd0, e_cv});
            check("R5 byte_count", byte_count, e_cnt);
            check("R6 param_valid", {7'd0, param_valid}, {7'd0, e_pv});
            check("R6 param_data", param_data, e_par);
            check("R7 frame_done", {7'd0, frame_done}, {7'd0, e_done});
            check("R8 frame_err", {7'd0, frame_err}, {7'd0, e_err});
            n_tv += task_valid; n_cv += count_valid; n_pv += param_valid;
            n_done += frame_done; n_err += frame_err;
        end
        if (stim.size() > 0) e = stim.pop_front(); else e = 9'h000;
        in_valid = e[8];
        in_data  = e[7:0];
        e_tv = 0; e_cv = 0; e_pv = 0; e_done = 0; e_err = 0;
        if (!rst_n) begin
            m_fld = 0; m_half = 0; m_hi = 0; m_left = 0;
            e_tid = 0; e_cnt = 0; e_par = 0;
        end else if (in_valid) begin
            hv = hexval(in_data);
            if (in_data == "z") begin
                m_fld = 1; m_half = 0;
            end else if (m_fld != 0) begin
                if (hv < 0) begin
                    e_err = 1; m_fld = 0; m_half = 0;
                end else if (m_half == 0) begin
                    m_hi = hv; m_half = 1;
                end else begin
                    b = m_hi * 16 + hv;
                    m_half = 0;
                    if (m_fld == 1) begin
                        e_tv = 1; e_tid = 8'(b); m_fld = 2;
                    end else if (m_fld == 2) begin
                        e_cv = 1; e_cnt = 8'(b); m_left = b;
                        if (b == 0) begin e_done = 1; m_fld = 0; end
                        else m_fld = 3;
                    end else begin
                        e_pv = 1; e_par = 8'(b); m_left--;
                        if (m_left == 0) begin e_done = 1; m_fld = 0; end
                    end
                end
            end
        end
    end

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n <= 1'b1;
        @(negedge clk); #1;
        // R1: reset state at the ports
        check("R1 strobes", {3'd0, task_valid, count_valid, param_valid, frame_done, frame_err}, 8'h00);
        check("R1 task_id", task_id, 8'h00);
        check("R1 byte_count", byte_count, 8'h00);
        check("R1 param_data", param_data, 8'h00);

        // R2: junk outside any frame
        put("ab1G9");
        drain();
        check("R2 pulses outside frame", 8'(n_tv + n_cv + n_pv + n_done + n_err), 8'd0);

        // R3 R4 R5 R6: mixed-case frame of three parameters
        put("z0A031f2E3c");
        drain();
        check("R4 mixed case last param", param_data, 8'h3C);
        check("R6 param count", 8'(n_pv), 8'd3);

        // R7: zero count
        put("z7f00");
        drain();
        check("R7 done count", 8'(n_done), 8'd2);

        // R10: gaps between characters
        put("z"); gap(2); put("1"); gap(3); put("2"); put("01"); gap(1); put("aB");
        drain();
        check("R10 gapped task", task_id, 8'h12);
        check("R10 gapped param", param_data, 8'hAB);

        // R8: illegal character, then hex ignored
        put("z120G34");
        drain();
        check("R8 error count", 8'(n_err), 8'd1);
        check("R8 no count after error", 8'(n_cv), 8'd3);

        // R9: restart mid-frame and mid-pair
        put("z5502AAz6601ff");
        put("z1z2200");
        drain();
        check("R9 task count", 8'(n_tv), 8'd7);
        check("R9 done count", 8'(n_done), 8'd5);
        check("R9 last task", task_id, 8'h22);
        check("R6 total params", 8'(n_pv), 8'd6);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule